// File: doc/BRIEF.md
# DMA Thread Wait-Instruction Executor

This block executes the two blocking wait instructions of a small DMA microcode engine for one thread. The thread may be the manager thread or a channel thread. A fetched two-byte instruction is offered with `issue_i`. It is accepted only while the executor is not already stalled.

The first opcode waits for a numbered event. The second waits for a request from a numbered peripheral. While the awaited condition is absent, the thread stays stalled. When the condition arrives, the executor gives a one-cycle release pulse.

An event is latched until one waiting thread consumes it. A peripheral request is a level, and its release is acknowledged with a one-hot pulse. Selecting a number that the build does not provide aborts the thread with a fault code instead of waiting. The wait-for-event form can also request an instruction-cache invalidate strobe.

The number of events and the number of peripherals are parameters. Instruction fetch, the other opcodes, data movement and the real cache sit outside the block.

Top module: `dmaw_exec`

## Requirements
- R1: Instruction byte 0 is `instr_i[7:0]` and byte 1 is `instr_i[15:8]`. The 5-bit target number is `instr_i[15:11]`, and `instr_i[10:8]` must be zero. Wait-for-event has byte0[7:2]=001101, byte0[1]=invalidate flag and byte0[0]=0. Wait-for-peripheral has byte0[7:2]=001100, with modifier byte0[1:0]: 00 single, 01 burst, 10 periph, 11 reserved.
- R2: After reset, `ready_o`=1, and `busy_o`, `done_o`, `fault_o`, `icache_inv_o`, `periph_ack_o`, `req_kind_o`, `fault_code_o` and `ev_pend_o` are all 0.
- R3: An accepted, fault-free wait whose target is absent at the accepting edge sets `busy_o`=1 and `ready_o`=0 from the next cycle. While busy, `issue_i` is ignored.
- R4: At the first edge where the target is present, `done_o` pulses for one cycle in the following cycle and `busy_o` returns to 0. A target already present at the accepting edge gives `done_o` in the next cycle without any busy cycle.
- R5: An `ev_set_i` bit latches its event into `ev_pend_o` at the next edge. An event that is set in the same cycle as the check counts as present. A release by event clears only that event's bit, so one event releases exactly one wait.
- R6: A wait-for-peripheral release drives `periph_ack_o` one-hot at the peripheral's index, together with `done_o`. `req_kind_o` then carries the modifier. Outside a peripheral release, both `periph_ack_o` and `req_kind_o` are 0.
- R7: `icache_inv_o` pulses for one cycle, in the cycle after a fault-free wait-for-event with the flag set is accepted. It never pulses when the flag is 0.
- R8: An event number of NUM_EVENTS or more gives fault code 1. A peripheral number of NUM_PERIPH or more gives fault code 2. Either fault appears as a one-cycle `fault_o` pulse in the next cycle, with no wait, no release, no invalidate and no consumption.
- R9: The following give fault code 3: an unknown byte 0, nonzero `instr_i[10:8]`, the reserved modifier, and a wait-for-peripheral issued with `mgr_i`=1. Code 3 takes priority over the range faults.
- R10: `done_o` and `fault_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction offered |
| instr_i | input | 16 | Two-byte instruction |
| mgr_i | input | 1 | Issuing thread is the manager thread |
| ev_set_i | input | NUM_EVENTS | Event signal pulses |
| periph_req_i | input | NUM_PERIPH | Peripheral request levels for this thread's channel |
| ready_o | output | 1 | Executor can accept an instruction |
| busy_o | output | 1 | Thread stalled on a wait |
| done_o | output | 1 | Wait released, thread may advance |
| periph_ack_o | output | NUM_PERIPH | One-hot acknowledge of the releasing request |
| req_kind_o | output | 2 | Modifier of the released peripheral wait |
| fault_o | output | 1 | Thread aborted |
| fault_code_o | output | 2 | Fault cause: 1 event range, 2 peripheral range, 3 illegal |
| icache_inv_o | output | 1 | Instruction-cache invalidate strobe |
| ev_pend_o | output | NUM_EVENTS | Latched, unconsumed events |

## Verification
The embedded assertions check four things on every cycle. Release and abort never coincide. The acknowledge is one-hot and accompanies a release. A busy cycle with its target present always ends the stall. Each invalidate strobe or fault code follows an accepted issue.

Other behaviours depend on chosen stimulus, and only the bench's scenarios can show them. These include one latched event serving exactly one of two back-to-back waits, same-cycle completion when the target is already present, and issues ignored while stalled. They also include each fault cause and its priority. Every one of these is compared cycle by cycle against a behavioural model.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  // R1 encodings
  localparam logic [5:0] OPC_WFE = 6'b001101;
  localparam logic [5:0] OPC_WFP = 6'b001100;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_EVENT   = 2'd1,
    FLT_PERIPH  = 2'd2,
    FLT_ILLEGAL = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    MOD_SINGLE = 2'd0,
    MOD_BURST  = 2'd1,
    MOD_PERIPH = 2'd2,
    MOD_RSVD   = 2'd3
  } pmod_e;

  typedef struct packed {
    logic       is_wfe;
    logic       is_wfp;
    logic       inval;
    pmod_e      mode;
    logic [4:0] num;
    flt_e       fault;
  } dec_t;
endpackage

// File: rtl/dmaw_decode.sv
module dmaw_decode
  import dmaw_pkg::*;
#(
  parameter int NUM_EVENTS = 16,
  parameter int NUM_PERIPH = 8
) (
  input  logic [15:0] instr_i,
  input  logic        mgr_i,
  output dec_t        dec_o
);
  logic [5:0] opc;
  logic       wfe, wfp, rsvd_ok;

  assign opc     = instr_i[7:2];
  assign wfe     = (opc == OPC_WFE) && !instr_i[0];
  assign wfp     = (opc == OPC_WFP);
  assign rsvd_ok = (instr_i[10:8] == 3'b000);

  always_comb begin
    dec_o.is_wfe = wfe;
    dec_o.is_wfp = wfp;
    dec_o.inval  = wfe & instr_i[1];
    dec_o.mode   = pmod_e'(instr_i[1:0]);
    dec_o.num    = instr_i[15:11];
    // illegal forms outrank range checks (R9)
    if (!(wfe || wfp) || !rsvd_ok)
      dec_o.fault = FLT_ILLEGAL;
    else if (wfp && (mgr_i || pmod_e'(instr_i[1:0]) == MOD_RSVD))
      dec_o.fault = FLT_ILLEGAL;
    else if (wfe && 32'(instr_i[15:11]) >= NUM_EVENTS)
      dec_o.fault = FLT_EVENT;
    else if (wfp && 32'(instr_i[15:11]) >= NUM_PERIPH)
      dec_o.fault = FLT_PERIPH;
    else
      dec_o.fault = FLT_NONE;
  end
endmodule

// File: rtl/dmaw_sel.sv
module dmaw_sel #(
  parameter int N = 16
) (
  input  logic [N-1:0] vec_i,
  input  logic [4:0]   num_i,
  output logic [N-1:0] onehot_o,
  output logic         hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign onehot_o[i] = (num_i == 5'(i));
  end
  assign hit_o = |(vec_i & onehot_o);
endmodule

// File: rtl/dmaw_evt.sv
module dmaw_evt #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] consume_i,
  output logic [N-1:0] eff_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  assign eff_o  = pend_q | set_i;
  assign pend_o = pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= eff_o[i] & ~consume_i[i];
    end
    AST_CONSUME_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      consume_i[i] |=> !pend_q[i]) else $error("consumed event left pending"); // R5
  end
endmodule

// File: rtl/dmaw_exec.sv
module dmaw_exec
  import dmaw_pkg::*;
#(
  parameter int NUM_EVENTS = 16,
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  issue_i,
  input  logic [15:0]           instr_i,
  input  logic                  mgr_i,
  input  logic [NUM_EVENTS-1:0] ev_set_i,
  input  logic [NUM_PERIPH-1:0] periph_req_i,
  output logic                  ready_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [NUM_PERIPH-1:0] periph_ack_o,
  output logic [1:0]            req_kind_o,
  output logic                  fault_o,
  output logic [1:0]            fault_code_o,
  output logic                  icache_inv_o,
  output logic [NUM_EVENTS-1:0] ev_pend_o
);
  dec_t dec;

  logic        busy_q, done_q, fault_q, inv_q;
  logic [4:0]  cur_num_q;
  logic        cur_wfp_q;
  pmod_e       cur_mode_q, kind_q;
  flt_e        code_q;
  logic [NUM_PERIPH-1:0] ack_q;

  logic        accept, start_ok, active, release_w, hit;
  logic [4:0]  sel_num;
  logic        sel_wfp;
  pmod_e       sel_mode;

  logic [NUM_EVENTS-1:0] ev_eff, ev_oh, ev_consume;
  logic [NUM_PERIPH-1:0] pr_oh, ack_d;
  logic                  ev_hit, pr_hit;

  dmaw_decode #(.NUM_EVENTS(NUM_EVENTS), .NUM_PERIPH(NUM_PERIPH)) u_dec (
    .instr_i (instr_i),
    .mgr_i   (mgr_i),
    .dec_o   (dec)
  );

  assign accept   = issue_i && !busy_q;
  assign start_ok = accept && (dec.fault == FLT_NONE);
  assign sel_num  = busy_q ? cur_num_q  : dec.num;
  assign sel_wfp  = busy_q ? cur_wfp_q  : dec.is_wfp;
  assign sel_mode = busy_q ? cur_mode_q : dec.mode;

  dmaw_evt #(.N(NUM_EVENTS)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ev_set_i),
    .consume_i (ev_consume),
    .eff_o     (ev_eff),
    .pend_o    (ev_pend_o)
  );

  dmaw_sel #(.N(NUM_EVENTS)) u_ev_sel (
    .vec_i    (ev_eff),
    .num_i    (sel_num),
    .onehot_o (ev_oh),
    .hit_o    (ev_hit)
  );

  dmaw_sel #(.N(NUM_PERIPH)) u_pr_sel (
    .vec_i    (periph_req_i),
    .num_i    (sel_num),
    .onehot_o (pr_oh),
    .hit_o    (pr_hit)
  );

  assign hit        = sel_wfp ? pr_hit : ev_hit;
  assign active     = busy_q || start_ok;
  assign release_w  = active && hit;
  assign ev_consume = (release_w && !sel_wfp) ? ev_oh : '0;
  assign ack_d      = (release_w &&  sel_wfp) ? pr_oh : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cur_num_q  <= '0;
      cur_wfp_q  <= 1'b0;
      cur_mode_q <= MOD_SINGLE;
    end else begin
      if (start_ok) begin
        cur_num_q  <= dec.num;
        cur_wfp_q  <= dec.is_wfp;
        cur_mode_q <= dec.mode;
      end
      if (start_ok && !hit)      busy_q <= 1'b1;
      else if (busy_q && hit)    busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      ack_q   <= '0;
      kind_q  <= MOD_SINGLE;
      fault_q <= 1'b0;
      code_q  <= FLT_NONE;
      inv_q   <= 1'b0;
    end else begin
      done_q  <= release_w;
      ack_q   <= ack_d;
      kind_q  <= (release_w && sel_wfp) ? sel_mode : MOD_SINGLE;
      fault_q <= accept && (dec.fault != FLT_NONE);
      code_q  <= accept ? dec.fault : FLT_NONE;
      inv_q   <= start_ok && dec.is_wfe && dec.inval;
    end
  end

  assign ready_o      = !busy_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign periph_ack_o = ack_q;
  assign req_kind_o   = kind_q;
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;
  assign icache_inv_o = inv_q;

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)) else $error("release and abort together"); // R10
  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(periph_ack_o)) else $error("ack not one-hot"); // R6
  AST_ACK_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|periph_ack_o) |-> done_o) else $error("ack without release"); // R6
  AST_BUSY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && hit) |=> (!busy_o && done_o)) else $error("stall not ended"); // R4
  AST_INV_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(icache_inv_o) |-> $past(issue_i && ready_o)) else $error("stray invalidate"); // R7
  AST_CODE_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_code_o != 2'd0) |-> $past(issue_i && ready_o)) else $error("stray fault code"); // R8
endmodule

// File: tb/tb_dmaw_exec.sv
`timescale 1ns/1ps
module tb_dmaw_exec;
  localparam int NE = 16;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [15:0] instr = '0;
  logic mgr = 1'b0;
  logic [NE-1:0] ev_set = '0;
  logic [NP-1:0] preq = '0;

  logic ready, busy, done, fault, inv;
  logic [NP-1:0] ack;
  logic [1:0] kind, code;
  logic [NE-1:0] pend;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dmaw_exec #(.NUM_EVENTS(NE), .NUM_PERIPH(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .instr_i(instr), .mgr_i(mgr),
    .ev_set_i(ev_set), .periph_req_i(preq), .ready_o(ready), .busy_o(busy),
    .done_o(done), .periph_ack_o(ack), .req_kind_o(kind), .fault_o(fault),
    .fault_code_o(code), .icache_inv_o(inv), .ev_pend_o(pend)
  );

  // behavioural reference model
  bit m_busy, m_wfp, m_done, m_fault, m_inv;
  int m_num, m_md, m_code, m_kind;
  logic [NE-1:0] m_pend;
  logic [NP-1:0] m_ack;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_wfp = 0; m_num = 0; m_md = 0;
      m_done = 0; m_fault = 0; m_inv = 0; m_code = 0; m_kind = 0;
      m_pend = '0; m_ack = '0;
    end else begin
      logic [NE-1:0] eff;
      bit go, h;
      int op, n, md, c;
      eff = m_pend | ev_set;
      go = 0;
      m_done = 0; m_fault = 0; m_inv = 0; m_code = 0; m_kind = 0; m_ack = '0;
      if (!m_busy && issue) begin
        op = int'(instr[7:2]); n = int'(instr[15:11]); md = int'(instr[1:0]); c = 0;
        if (!((op == 13 && !instr[0]) || op == 12) || instr[10:8] != 0) c = 3;
        else if (op == 12 && (mgr || md == 3)) c = 3;
        else if (op == 13 && n >= NE) c = 1;
        else if (op == 12 && n >= NP) c = 2;
        if (c != 0) begin m_fault = 1; m_code = c; end
        else begin
          go = 1; m_num = n; m_wfp = (op == 12); m_md = md;
          m_inv = (op == 13) && instr[1];
        end
      end
      if (go || m_busy) begin
        h = m_wfp ? preq[m_num] : eff[m_num];
        if (h) begin
          m_done = 1; m_busy = 0;
          if (m_wfp) begin m_ack[m_num] = 1'b1; m_kind = m_md; end
          else eff[m_num] = 1'b0;
        end else m_busy = 1;
      end
      m_pend = eff;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 busy", busy, m_busy);
    chk("R3 ready", ready, !m_busy);
    chk("R1 R4 done", done, m_done);
    chk("R5 ev_pend", pend, m_pend);
    chk("R6 ack", ack, m_ack);
    chk("R6 kind", kind, m_kind);
    chk("R7 inv", inv, m_inv);
    chk(m_code == 3 ? "R9 fault" : "R8 fault", fault, m_fault);
    chk(m_code == 3 ? "R9 code" : "R8 code", code, m_code);
    chk("R10 excl", done && fault, 0);
  end

  function automatic logic [15:0] wfe(bit iv, int n);
    return {5'(n), 3'b000, 6'b001101, iv, 1'b0};
  endfunction
  function automatic logic [15:0] wfp(int md, int n);
    return {5'(n), 3'b000, 6'b001100, 2'(md)};
  endfunction

  task automatic cyc(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask
  task automatic iss(logic [15:0] w, bit m);
    @(posedge clk); #1; issue = 1; instr = w; mgr = m;
    @(posedge clk); #1; issue = 0; mgr = 0;
  endtask
  task automatic evp(int i);
    @(posedge clk); #1; ev_set[i] = 1'b1;
    @(posedge clk); #1; ev_set = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    #2;
    chk("R2 reset ready", ready, 1); chk("R2 reset busy", busy, 0);
    chk("R2 reset done", done, 0);   chk("R2 reset fault", fault, 0);
    chk("R2 reset pend", pend, 0);   chk("R2 reset ack", ack, 0);
    rst_n = 1'b1;
    cyc(2);
    // R3 R4 R5: wait on absent event, then signal it
    iss(wfe(0, 3), 0); cyc(3); evp(3); cyc(3);
    // R7 R4: pending event, immediate completion with invalidate
    evp(5); cyc(1); iss(wfe(1, 5), 1); cyc(2);
    // R5: one event serves only one of two waits
    evp(2); iss(wfe(0, 2), 0); iss(wfe(0, 2), 0); cyc(3); evp(2); cyc(2);
    // R5: event set in the accepting cycle counts
    @(posedge clk); #1; issue = 1; instr = wfe(0, 9); ev_set[9] = 1'b1;
    @(posedge clk); #1; issue = 0; ev_set = '0; cyc(2);
    // R3: issue ignored while stalled
    iss(wfe(0, 7), 0); evp(0); iss(wfe(1, 0), 0); cyc(2); evp(7); cyc(3);
    // R8 range faults
    iss(wfe(1, 20), 0); iss(wfe(0, 16), 0); iss(wfp(0, 9), 0); cyc(2);
    // R6 peripheral waits: delayed and immediate
    iss(wfp(1, 2), 0); cyc(3);
    @(posedge clk); #1; preq[2] = 1'b1; cyc(2); preq = '0;
    preq[7] = 1'b1; iss(wfp(2, 7), 0); cyc(2); preq = '0;
    iss(wfp(0, 0), 0); cyc(1); preq[1] = 1'b1; cyc(2); preq[0] = 1'b1; cyc(2); preq = '0;
    // R9 illegal forms
    iss(wfp(3, 1), 0); iss(wfp(0, 1), 1); iss(16'h0011, 0);
    iss(wfe(0, 1) | 16'h0100, 0); iss(wfe(0, 1) | 16'h0001, 0); iss(wfp(0, 20), 1);
    cyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule